// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This block turns the output of an ordinary binary addition of two packed BCD bytes into a correct packed BCD result. It sits after a plain binary adder. It takes the binary sum, the carry out of the top bit and the carry out of bit 3 (the half carry). It returns the decimal-correct digits and the decimal carry. The decision for each digit is made nibble by nibble. A digit gets +6 when its flag is set or when its value is over 9. The high digit is checked only after the low digit has been corrected. This way a low-digit correction that pushes the high digit past 9 is also repaired.

The digit count is a parameter, default two. For a two-digit byte the low digit uses the half carry and the high digit uses the binary carry. An optional output register adds one cycle of latency; it is on by default. Both operands of the earlier addition are taken to be valid packed BCD.

Top module: `bcd_dec_adjust`

## Requirements
- R1: When the low nibble of `sum_i` (bits 3:0) is greater than 9, 0x06 is added to the sum.
- R2: When `half_carry_i` is 1, 0x06 is added to the sum, even if the low nibble is 9 or less.
- R3: When `carry_i` is 1, 0x60 is added and `carry_o` is 1.
- R4: When the high nibble (bits 7:4) is greater than 9 after the low-digit step, 0x60 is added and `carry_o` is 1. Otherwise `carry_o` equals `carry_i`.
- R5: The high-digit check uses the sum after the low correction. For example, a sum of 0x9A with both flags clear gives 0x00 with `carry_o` = 1.
- R6: When no condition holds (both nibbles ≤ 9 and both flags 0), `result_o` equals `sum_i` and `carry_o` is 0.
- R7: Take any packed BCD operands a and b (each 00..99). Feed in the binary a+b (low 8 bits), its carry out of bit 7 and its carry out of bit 3. Then `result_o` is (a+b) mod 100 in packed BCD, and `carry_o` is 1 exactly when a+b ≥ 100. Cases: 0x43+0x39 → 0x82, carry 0. 0x49+0x49 → 0x98, carry 0. 0x50+0x50 → 0x00, carry 1.
- R8: With `OUT_REG`=1 (the default), outputs show the result of the inputs sampled at the previous rising edge of `clk_i`. While `rst_ni` is low, `result_o` and `carry_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sum_i | input | 4*DIGITS (8) | Binary sum from the earlier add |
| carry_i | input | 1 | Carry out of the top bit of the binary add |
| half_carry_i | input | 1 | Carry out of bit 3 of the binary add |
| result_o | output | 4*DIGITS (8) | Corrected packed BCD result |
| carry_o | output | 1 | Decimal carry out |

## Verification
The bench covers several corner cases, each of which exposes a specific design error:
- **0x9A with no flags.** It needs the high check after the low correction. A design that checks the high digit on the raw sum returns 0xA0 with no carry.
- **Half carry with a low digit at or below 9,** as in 0x49+0x49. A design that ignores the half carry returns 0x92.
- **Carry-in with a small high digit,** as in 0x99+0x99 giving binary 0x32. A design that uses only the range tests loses the hundred.

Every pair of valid BCD operands is run against a decimal reference. Random raw inputs, including invalid digit patterns, are checked against the rule-based model.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned DIGIT_MAX = 9;
  localparam logic [NIB_W-1:0] FIX_VAL = 4'd6;

  function automatic logic nib_over(input logic [NIB_W-1:0] nib);
    return nib > NIB_W'(DIGIT_MAX);
  endfunction
endpackage

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
  import bcd_adj_pkg::*;
#(
  parameter int unsigned W   = 8,
  parameter int unsigned IDX = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  input  logic         flag_i,
  output logic [W-1:0] val_o,
  output logic         cout_o,
  output logic         fix_o
);
  localparam int unsigned LSB = IDX * NIB_W;

  logic [NIB_W-1:0] dig;
  logic [W:0]       addend;
  logic [W:0]       total;

  assign dig    = val_i[LSB +: NIB_W];
  assign fix_o  = flag_i | nib_over(dig);
  assign addend = fix_o ? ((W+1)'(FIX_VAL) << LSB) : '0;
  assign total  = {1'b0, val_i} + addend;
  assign val_o  = total[W-1:0];
  assign cout_o = total[W];

  // R1 / R4: out-of-range digit must be corrected
  a_r1_range_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_over(dig) |-> (val_o != val_i));
  // R2 / R3: a set flag forces a correction
  a_r2_flag_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i |-> ({cout_o, val_o} == {1'b0, val_i} + ((W+1)'(6) << LSB)));
  // R6: no condition, value untouched
  a_r6_no_fix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_i && !nib_over(dig)) |-> (val_o == val_i && !cout_o));
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage #(
  parameter int unsigned W       = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] val_i,
  input  logic         carry_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_o   <= '0;
        carry_o <= 1'b0;
      end else begin
        val_o   <= val_i;
        carry_o <= carry_i;
      end
    end

    // R8: one cycle latency
    a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (val_o == $past(val_i) && carry_o == $past(carry_i)));
  end else begin : g_comb
    assign val_o   = val_i;
    assign carry_o = carry_i;
  end
endmodule

// File: rtl/bcd_dec_adjust.sv
module bcd_dec_adjust
  import bcd_adj_pkg::*;
#(
  parameter int unsigned DIGITS  = 2,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DIGITS*NIB_W-1:0] sum_i,
  input  logic                    carry_i,
  input  logic                    half_carry_i,
  output logic [DIGITS*NIB_W-1:0] result_o,
  output logic                    carry_o
);
  localparam int unsigned W = DIGITS * NIB_W;

  logic [W-1:0]      val_w [DIGITS+1];
  logic [DIGITS:0]   cout_w;
  logic [DIGITS-1:0] flag_w;
  logic [DIGITS-1:0] fix_w;
  logic              carry_c;

  assign val_w[0]  = sum_i;
  assign cout_w[0] = 1'b0;

  // digits corrected low to high; each sees the lower corrections
  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    logic lo_flag, hi_flag;
    if (d == 0) begin : g_lo
      assign lo_flag = half_carry_i;
    end else begin : g_nlo
      assign lo_flag = 1'b0;
    end
    if (d == DIGITS-1) begin : g_hi
      assign hi_flag = carry_i | (|cout_w[d:0]);
    end else begin : g_nhi
      assign hi_flag = 1'b0;
    end
    assign flag_w[d] = lo_flag | hi_flag;

    bcd_digit_stage #(.W(W), .IDX(d)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .val_i  (val_w[d]),
      .flag_i (flag_w[d]),
      .val_o  (val_w[d+1]),
      .cout_o (cout_w[d+1]),
      .fix_o  (fix_w[d])
    );
  end

  assign carry_c = fix_w[DIGITS-1];

  bcd_out_stage #(.W(W), .OUT_REG(OUT_REG)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .val_i   (val_w[DIGITS]),
    .carry_i (carry_c),
    .val_o   (result_o),
    .carry_o (carry_o)
  );

  // R3: incoming carry is never lost
  a_r3_carry_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_i |-> carry_c);
  // R4: overflow of the top stage always shows as decimal carry
  a_r4_top_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cout_w[DIGITS] |-> carry_c);
  // R4: no carry without a reason
  a_r4_carry_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (carry_c && !carry_i) |-> (nib_over(val_w[DIGITS-1][W-1 -: NIB_W]) || (|cout_w[DIGITS-1:0])
                                || (DIGITS == 1 && half_carry_i)));
endmodule

// File: tb/bcd_dec_adjust_tb_top.sv
module bcd_dec_adjust_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WD_LIMIT   = 100000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sum_i = '0;
  logic       carry_i = 1'b0;
  logic       half_carry_i = 1'b0;
  logic [7:0] result_o;
  logic       carry_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bcd_dec_adjust dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sum_i(sum_i), .carry_i(carry_i),
    .half_carry_i(half_carry_i), .result_o(result_o), .carry_o(carry_o)
  );

  function automatic logic [8:0] rule_ref(input logic [7:0] s, input logic c, input logic hc);
    logic [8:0] t;
    logic       hi;
    t  = {1'b0, s} + ((hc || s[3:0] > 4'd9) ? 9'h06 : 9'h00);
    hi = c || t[8] || (t[7:4] > 4'd9);
    t  = {1'b0, t[7:0]} + (hi ? 9'h60 : 9'h00);
    return {hi, t[7:0]};
  endfunction

  function automatic logic [8:0] dec_ref(input int a, input int b);
    int s;
    s = a + b;
    return {(s >= 100), 4'((s % 100) / 10), 4'(s % 10)};
  endfunction

  function automatic logic [7:0] to_bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic check(input string req, input logic [8:0] exp);
    checks++;
    if ({carry_o, result_o} !== exp) begin
      errors++;
      $display("FAIL %s: actual carry=%0b result=%02h expected carry=%0b result=%02h",
               req, carry_o, result_o, exp[8], exp[7:0]);
    end
  endtask

  task automatic apply(input logic [7:0] s, input logic c, input logic hc);
    @(negedge clk_i);
    sum_i = s; carry_i = c; half_carry_i = hc;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic run_pair(input int a, input int b, input string req);
    logic [8:0] bin;
    logic       hc;
    bin = {1'b0, to_bcd(a)} + {1'b0, to_bcd(b)};
    hc  = ({1'b0, to_bcd(a)} & 5'h0F) + ({1'b0, to_bcd(b)} & 5'h0F) > 5'h0F;
    hc  = (5'(to_bcd(a) & 8'h0F) + 5'(to_bcd(b) & 8'h0F)) > 5'd15;
    apply(bin[7:0], bin[8], hc);
    check(req, dec_ref(a, b));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (!done && cycles > WD_LIMIT) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual cycles %0d expected < %0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    logic [7:0] s;
    logic       c, hc;
    void'($urandom(32'd1234));
    sum_i = 8'h55; carry_i = 1'b1; half_carry_i = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R8 reset", 9'h000);
    rst_ni = 1'b1;

    apply(8'h7C, 1'b0, 1'b0); check("R1 0x43+0x39", 9'h082);
    apply(8'h92, 1'b0, 1'b1); check("R2 0x49+0x49", 9'h098);
    apply(8'hA0, 1'b0, 1'b0); check("R4 0x50+0x50", 9'h100);
    apply(8'h32, 1'b1, 1'b1); check("R3 0x99+0x99", 9'h198);
    apply(8'h10, 1'b1, 1'b0); check("R3 carry only", 9'h170);
    apply(8'h9A, 1'b0, 1'b0); check("R5 low fix spills", 9'h100);
    apply(8'h45, 1'b0, 1'b0); check("R6 passthrough", 9'h045);
    apply(8'h99, 1'b0, 1'b0); check("R6 top valid", 9'h099);
    apply(8'h00, 1'b0, 1'b0); check("R6 zero", 9'h000);

    // R8: back-to-back values appear one cycle later each
    @(negedge clk_i); sum_i = 8'h0B; carry_i = 1'b0; half_carry_i = 1'b0;
    @(negedge clk_i); check("R8 pipe first", 9'h011);
    sum_i = 8'h21;
    @(negedge clk_i); check("R8 pipe second", 9'h021);

    // R7: every valid BCD pair
    for (int a = 0; a < 100; a++)
      for (int b = 0; b < 100; b++)
        run_pair(a, b, "R7 exhaustive");

    // R1..R5: random raw inputs against the rule model
    for (int i = 0; i < 3000; i++) begin
      s  = 8'($urandom);
      c  = 1'($urandom);
      hc = 1'($urandom);
      apply(s, c, hc);
      check("R4 random rules", rule_ref(s, c, hc));
    end

    done = 1'b1;
    finish_run();
  end
endmodule